// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block gathers up to sixteen internal event pulses into a sticky status register and drives a single active-high interrupt line toward the host. Each source pulse lasts one clock cycle and sets its status bit. The bit stays set until the host clears it. A per-bit mask decides which set status bits may raise the host line. A 1 in the mask blocks that bit.

The host reaches the block through a simple register bus with an address, a write strobe, a read strobe and 32-bit data. There are six views:
- the mask itself, which can be read and written;
- a write-only alias that sets mask bits;
- a write-only alias that clears mask bits;
- a status read that leaves the status unchanged;
- a status read that clears every bit after returning it;
- a write-only acknowledge view that clears the status bits written as 1.

With the set and clear aliases, separate software agents can change mask bits without a read-modify-write sequence. Read data is registered and appears on the bus in the cycle after the read strobe.

Top module: `host_irq_ctrl`

## Requirements
- R1: After reset the mask holds 0x0001, the status is zero, the host line is low and the read data is zero.
- R2: A 1 on source bit n in a cycle sets status bit n at the next clock edge, and the bit stays set until it is cleared. The bit assignment is: bit 0 receive buffer 0, bit 1 transmit data, bit 2 transmit transfer, bit 3 receive buffer 1, bit 4 receive transfer, bits 5 and 6 event mailbox, bit 7 wake, bits 8 and 9 trace, bit 10 command complete, bit 14 init complete.
- R3: A write to the mask view (offset 0x00) replaces all sixteen mask bits with write data bits 15:0. A read of that view returns the mask in bits 15:0 and zero in bits 31:16.
- R4: A write to the mask-set view (offset 0x04) sets each mask bit whose write data bit is 1. Mask bits written as 0 keep their value.
- R5: A write to the mask-clear view (offset 0x08) clears each mask bit whose write data bit is 1. Mask bits written as 0 keep their value.
- R6: A read of the keep-status view (offset 0x0C) returns the status in bits 15:0 and does not change it.
- R7: A read of the take-status view (offset 0x10) returns the status and then clears every status bit.
- R8: A write to the acknowledge view (offset 0x14) clears each status bit written as 1. Bits written as 0 have no effect.
- R9: The host line is high one cycle after any status bit is set while its mask bit is 0. It is low one cycle after no such bit exists.
- R10: If a source pulse on a bit arrives in the same cycle as a take-status read or an acknowledge of that bit, the bit stays set.
- R11: Reads of the write-only views and of unmapped offsets return zero. Writes to the status read views and to unmapped offsets change neither the mask nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | NUM_SRC (16) | One-cycle event pulses from the internal sources |
| bus_addr | input | ADDR_W (8) | Byte offset of the register view |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data, valid the cycle after the read strobe |
| host_irq | output | 1 | Active-high interrupt to the host |

## Verification
The bench targets the cycle in which a new event meets a take-status read or an acknowledge of the same bit. A design that gives the clear priority drops that event, and the bench reads the status as zero where it expects the bit set. The bench writes patterns with mixed ones and zeros through the set and clear aliases. A design that treats these aliases as plain writes disturbs the bits written as zero. The bench reads the keep-status view twice in a row to find a read that clears. It also reads the write-only and unmapped offsets and writes to the read views, which catches a decoder that aliases views onto one another. The bench checks the host line against masked and unmasked pending bits, so it catches an inverted mask sense or a line that ignores the mask.

// File: rtl/host_irq_pkg.sv
package host_irq_pkg;

    // Byte offsets of the register views
    localparam logic [7:0] OFS_MASK      = 8'h00;
    localparam logic [7:0] OFS_MASK_SET  = 8'h04;
    localparam logic [7:0] OFS_MASK_CLR  = 8'h08;
    localparam logic [7:0] OFS_STAT_KEEP = 8'h0C;
    localparam logic [7:0] OFS_STAT_TAKE = 8'h10;
    localparam logic [7:0] OFS_ACK       = 8'h14;

    // Which value a read returns
    typedef enum logic [1:0] {
        RV_ZERO,
        RV_MASK,
        RV_STATUS
    } rd_view_e;

    // Decoded bus operation for one cycle
    typedef struct packed {
        logic mask_wr;
        logic mask_set;
        logic mask_clr;
        logic ack_wr;
        logic keep_rd;
        logic take_rd;
        logic mask_rd;
    } bus_op_t;

endpackage

// File: rtl/host_irq_regdec.sv
module host_irq_regdec
    import host_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output bus_op_t           op,
    output rd_view_e          rd_view
);

    logic hit_mask;
    logic hit_set;
    logic hit_clr;
    logic hit_keep;
    logic hit_take;
    logic hit_ack;

    always_comb begin
        hit_mask = (bus_addr == ADDR_W'(OFS_MASK));
        hit_set  = (bus_addr == ADDR_W'(OFS_MASK_SET));
        hit_clr  = (bus_addr == ADDR_W'(OFS_MASK_CLR));
        hit_keep = (bus_addr == ADDR_W'(OFS_STAT_KEEP));
        hit_take = (bus_addr == ADDR_W'(OFS_STAT_TAKE));
        hit_ack  = (bus_addr == ADDR_W'(OFS_ACK));
    end

    always_comb begin
        op          = '0;
        op.mask_wr  = bus_wr & hit_mask;
        op.mask_set = bus_wr & hit_set;
        op.mask_clr = bus_wr & hit_clr;
        op.ack_wr   = bus_wr & hit_ack;
        op.keep_rd  = bus_rd & hit_keep;
        op.take_rd  = bus_rd & hit_take;
        op.mask_rd  = bus_rd & hit_mask;
    end

    always_comb begin
        if (op.mask_rd) begin
            rd_view = RV_MASK;
        end else if (op.keep_rd || op.take_rd) begin
            rd_view = RV_STATUS;
        end else begin
            rd_view = RV_ZERO;
        end
    end

endmodule

// File: rtl/host_irq_mask.sv
module host_irq_mask
    import host_irq_pkg::*;
#(
    parameter int              NUM_SRC  = 16,
    parameter logic [NUM_SRC-1:0] MASK_RST = NUM_SRC'(1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bus_op_t            op,
    input  logic [NUM_SRC-1:0] wbits,
    output logic [NUM_SRC-1:0] mask_q
);

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
    } mask_state_t;

    mask_state_t st_d;
    mask_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (op.mask_wr) begin
            st_d.mask = wbits;
        end else if (op.mask_set) begin
            st_d.mask = st_q.mask | wbits;
        end else if (op.mask_clr) begin
            st_d.mask = st_q.mask & ~wbits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= MASK_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q = st_q.mask;

endmodule

// File: rtl/host_irq_status.sv
module host_irq_status
    import host_irq_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  bus_op_t            op,
    input  logic [NUM_SRC-1:0] wbits,
    output logic [NUM_SRC-1:0] status_q
);

    typedef struct packed {
        logic [NUM_SRC-1:0] stat;
    } stat_state_t;

    stat_state_t        st_d;
    stat_state_t        st_q;
    logic [NUM_SRC-1:0] clr_vec;

    // Clear request per bit: take-read clears all, acknowledge clears written ones
    for (genvar b = 0; b < NUM_SRC; b++) begin : g_clr
        assign clr_vec[b] = op.take_rd | (op.ack_wr & wbits[b]);
    end

    // New events are applied after the clear, so they win a same-cycle race
    always_comb begin
        st_d      = st_q;
        st_d.stat = (st_q.stat & ~clr_vec) | src_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_q = st_q.stat;

endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
    import host_irq_pkg::*;
#(
    parameter int                 NUM_SRC  = 16,
    parameter int                 ADDR_W   = 8,
    parameter int                 DATA_W   = 32,
    parameter logic [NUM_SRC-1:0] MASK_RST = NUM_SRC'(1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               host_irq
);

    localparam int PAD_W = DATA_W - NUM_SRC;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              irq;
    } top_state_t;

    bus_op_t            op;
    rd_view_e           rd_view;
    logic [NUM_SRC-1:0] wbits;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] status_q;
    logic               unused_wdata_hi;
    top_state_t         st_d;
    top_state_t         st_q;

    assign wbits           = bus_wdata[NUM_SRC-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

    host_irq_regdec #(
        .ADDR_W (ADDR_W)
    ) u_regdec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .op       (op),
        .rd_view  (rd_view)
    );

    host_irq_mask #(
        .NUM_SRC  (NUM_SRC),
        .MASK_RST (MASK_RST)
    ) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .wbits  (wbits),
        .mask_q (mask_q)
    );

    host_irq_status #(
        .NUM_SRC (NUM_SRC)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_evt  (src_evt),
        .op       (op),
        .wbits    (wbits),
        .status_q (status_q)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(status_q & ~mask_q);
        if (bus_rd) begin
            unique case (rd_view)
                RV_MASK:   st_d.rdata = {{PAD_W{1'b0}}, mask_q};
                RV_STATUS: st_d.rdata = {{PAD_W{1'b0}}, status_q};
                default:   st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign host_irq  = st_q.irq;

endmodule

// File: rtl/host_irq_ctrl_chk.sv
module host_irq_ctrl_chk
    import host_irq_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_evt,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               host_irq,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] mask_q
);

    logic               c_set;
    logic               c_clr;
    logic               c_ack;
    logic               c_take;
    logic               c_keep_only;
    logic [NUM_SRC-1:0] c_w;

    assign c_w         = bus_wdata[NUM_SRC-1:0];
    assign c_set       = bus_wr && (bus_addr == ADDR_W'(OFS_MASK_SET));
    assign c_clr       = bus_wr && (bus_addr == ADDR_W'(OFS_MASK_CLR));
    assign c_ack       = bus_wr && (bus_addr == ADDR_W'(OFS_ACK));
    assign c_take      = bus_rd && (bus_addr == ADDR_W'(OFS_STAT_TAKE));
    assign c_keep_only = bus_rd && !bus_wr && (bus_addr == ADDR_W'(OFS_STAT_KEEP));

    a_r2_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt != '0) |=> ((status_q & $past(src_evt)) == $past(src_evt)));

    a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
        c_set |=> ((mask_q & $past(c_w)) == $past(c_w)));

    a_r5_clr: assert property (@(posedge clk) disable iff (!rst_n)
        c_clr |=> ((mask_q & $past(c_w)) == '0));

    a_r6_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (c_keep_only && src_evt == '0) |=> $stable(status_q));

    a_r7_take: assert property (@(posedge clk) disable iff (!rst_n)
        (c_take && !c_ack && src_evt == '0) |=> (status_q == '0));

    a_r8_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ack && src_evt == '0) |=> ((status_q & $past(c_w)) == '0));

    a_r9_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~mask_q) == '0) |=> !host_irq);

    a_r9_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~mask_q) != '0) |=> host_irq);

    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_take || c_ack) && src_evt != '0) |=> ((status_q & $past(src_evt)) != '0));

endmodule

bind host_irq_ctrl host_irq_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_evt   (src_evt),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .host_irq  (host_irq),
    .status_q  (status_q),
    .mask_q    (mask_q)
);

// File: tb/host_irq_ctrl_bench.sv
`timescale 1ns/1ps
module host_irq_ctrl_bench;

    localparam logic [7:0] A_MASK = 8'h00;
    localparam logic [7:0] A_SET  = 8'h04;
    localparam logic [7:0] A_CLR  = 8'h08;
    localparam logic [7:0] A_KEEP = 8'h0C;
    localparam logic [7:0] A_TAKE = 8'h10;
    localparam logic [7:0] A_ACK  = 8'h14;
    localparam logic [7:0] A_HOLE = 8'h3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_evt = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        host_irq;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_mask = 16'h0001;
    logic [15:0] m_stat = 16'h0000;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #5 clk = ~clk;

    host_irq_ctrl u_host_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_evt   (src_evt),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .host_irq  (host_irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: compares each read result against the scoreboard queue
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard underflow", bus_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    task automatic pulse(input logic [15:0] s);
        src_evt = s;
        @(negedge clk);
        src_evt = '0;
        m_stat  = m_stat | s;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [15:0] s);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        src_evt   = s;
        @(negedge clk);
        bus_wr  = 1'b0;
        src_evt = '0;
        case (a)
            A_MASK:  m_mask = d[15:0];
            A_SET:   m_mask = m_mask | d[15:0];
            A_CLR:   m_mask = m_mask & ~d[15:0];
            A_ACK:   m_stat = m_stat & ~d[15:0];
            default: ;
        endcase
        m_stat = m_stat | s;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag, input logic [15:0] s);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_addr = a;
        bus_rd   = 1'b1;
        src_evt  = s;
        @(negedge clk);
        bus_rd  = 1'b0;
        src_evt = '0;
        if (a == A_TAKE) m_stat = '0;
        m_stat = m_stat | s;
    endtask

    task automatic check_irq(input string tag);
        logic e;
        @(negedge clk);
        e = |(m_stat & ~m_mask);
        check(host_irq === e, tag, {31'h0, host_irq}, {31'h0, e});
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'h0, 32'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(host_irq === 1'b0, "R1 irq low after reset", {31'h0, host_irq}, 32'h0);
        check(bus_rdata === 32'h0, "R1 rdata zero after reset", bus_rdata, 32'h0);
        rd(A_MASK, 32'h0000_0001, "R1 mask reset value", 16'h0);
        rd(A_KEEP, 32'h0, "R1 status reset value", 16'h0);

        // R2/R9: masked bit 0 latches without raising the line
        pulse(16'h0001);
        check_irq("R9 masked bit keeps irq low");
        rd(A_KEEP, 32'h0000_0001, "R2 bit0 latched", 16'h0);
        rd(A_KEEP, 32'h0000_0001, "R6 keep read leaves status", 16'h0);

        // R2/R9: init complete (bit 14) raises the line
        pulse(16'h4000);
        check_irq("R9 unmasked bit14 raises irq");
        rd(A_KEEP, 32'h0000_4001, "R2 bit14 latched", 16'h0);

        // R4: set alias, upper data bits ignored
        wr(A_SET, 32'hFFFF_C000, 16'h0);
        check_irq("R4 set alias masks bit14");
        rd(A_MASK, 32'h0000_C001, "R4 set alias merge, R3 upper zero", 16'h0);

        // R5: clear alias
        wr(A_CLR, 32'h0000_4000, 16'h0);
        rd(A_MASK, 32'h0000_8001, "R5 clear alias leaves zero bits", 16'h0);
        check_irq("R5 unmasking bit14 raises irq");

        // R8: acknowledge bit 0 only
        wr(A_ACK, 32'h0000_0001, 16'h0);
        rd(A_KEEP, 32'h0000_4000, "R8 ack clears only written bit", 16'h0);

        // R7: take read clears all
        pulse(16'h0606);
        rd(A_TAKE, 32'h0000_4606, "R7 take read returns status", 16'h0);
        rd(A_KEEP, 32'h0, "R7 status cleared after take", 16'h0);
        check_irq("R7 irq low after take");

        // R3: full mask write; R8/R9 ack toward masked remainder
        wr(A_MASK, 32'hABCD_00F0, 16'h0);
        rd(A_MASK, 32'h0000_00F0, "R3 mask write replaces", 16'h0);
        pulse(16'h00FF);
        check_irq("R9 unmasked low nibble raises irq");
        wr(A_ACK, 32'h0000_000F, 16'h0);
        check_irq("R9 only masked bits remain, irq low");
        rd(A_KEEP, 32'h0000_00F0, "R8 ack of low nibble", 16'h0);

        // R10: event races with take read and with acknowledge
        rd(A_TAKE, 32'h0000_00F0, "R10 take read during event", 16'h0100);
        rd(A_KEEP, 32'h0000_0100, "R10 event survives take read", 16'h0);
        wr(A_ACK, 32'h0000_0100, 16'h0100);
        rd(A_KEEP, 32'h0000_0100, "R10 event survives ack", 16'h0);

        // R11: write-only views and holes read zero; writes to read views ignored
        wr(A_KEEP, 32'h0000_FFFF, 16'h0);
        wr(A_TAKE, 32'h0000_FFFF, 16'h0);
        wr(A_HOLE, 32'h0000_FFFF, 16'h0);
        rd(A_KEEP, 32'h0000_0100, "R11 writes to read views ignored", 16'h0);
        rd(A_MASK, 32'h0000_00F0, "R11 mask untouched by hole write", 16'h0);
        rd(A_SET, 32'h0, "R11 set alias reads zero", 16'h0);
        rd(A_CLR, 32'h0, "R11 clear alias reads zero", 16'h0);
        rd(A_ACK, 32'h0, "R11 ack view reads zero", 16'h0);
        rd(A_HOLE, 32'h0, "R11 unmapped reads zero", 16'h0);
        rd(A_KEEP, 32'h0000_0100, "R11 zero reads left status", 16'h0);
        check_irq("R9 bit8 unmasked keeps irq high");

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule